// File: doc/BRIEF.md
# Three-wire panel register writer

This block writes configuration registers of a display panel over a three-wire serial link made of an active-low select line, a serial clock and a data line. Every transfer is a 16-bit word holding an 8-bit register address in its upper byte and an 8-bit value in its lower byte. Bits go out most significant first and are launched while the clock is low, so the panel samples each one on a rising clock edge.

Three request inputs start the transfers, one at a time. The first writes an arbitrary address and value. The second issues the fixed display-off write. The third runs a fixed power-on list of five writes back to back. A `busy` output covers the whole of a request. A one-cycle `done` pulse marks the end of every write, and `seq_done` marks the end of the power-on list.

A divider input sets the length of every serial-clock half-period in system clocks. The divider value is captured when each write begins.

Top module: `panel_cfg_writer`

## Requirements
- R1: A write sends the word {address[7:0], value[7:0]} on `pnl_sdo`, most significant bit first, with the address in bits 15:8.
- R2: While idle, `pnl_cs_n` and `pnl_sclk` are high and `pnl_sdo` is low. `pnl_cs_n` falls while `pnl_sclk` is still high and `pnl_sdo` is still low.
- R3: For each bit, `pnl_sclk` falls and `pnl_sdo` takes the new bit in that same cycle. `pnl_sdo` does not change while `pnl_sclk` is high within a frame.
- R4: Each frame has exactly 16 rising edges of `pnl_sclk`. `pnl_cs_n` rises one half-period after the 16th rising edge.
- R5: Every half-period of `pnl_sclk`, and every phase of a frame, lasts `half_div`+1 system clocks. The `half_div` value is captured at the start of each write, and later changes do not affect a write already running.
- R6: `busy` is high from the clock edge that accepts a request until `pnl_cs_n` has been high for one half-period after the last frame. `done` pulses for exactly one cycle in the cycle that `busy` falls for a single write.
- R7: A request raised while `busy` is high is ignored. It causes no frame, and the write in progress is not disturbed.
- R8: `seq_start` sends five frames in this order: 051E, 055E, 078D, 1301, 055F (address byte then value byte, hex). `busy` stays high between them.
- R9: During the power-on list, `done` pulses once per frame (five times). `seq_done` pulses once, in the same cycle as the fifth `done`, and `busy` is low in that cycle.
- R10: `off_start` sends the single frame 055E, ignoring `wr_addr` and `wr_data`.
- R11: When more than one request arrives in the same idle cycle, `seq_start` wins over `off_start`, and `off_start` wins over `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_div | input | DIV_W | Serial half-period length minus one, in system clocks |
| start | input | 1 | Request a write of wr_addr/wr_data |
| off_start | input | 1 | Request the display-off write |
| seq_start | input | 1 | Request the power-on list |
| wr_addr | input | 8 | Register address for `start` |
| wr_data | input | 8 | Register value for `start` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at the end of each write |
| seq_done | output | 1 | One-cycle pulse at the end of the power-on list |
| pnl_cs_n | output | 1 | Active-low frame select |
| pnl_sclk | output | 1 | Serial clock, idles high |
| pnl_sdo | output | 1 | Serial data, changes while the clock is low |

## Verification
The hardest situation to reach is the hand-off inside the power-on list. In the single cycle where one frame's closing phase ends, the next frame must start from the list, with a freshly captured divider and no extra idle gap. The bench gets there by running the whole list and decoding all five frames from the pins. It also combines the list request with the other two requests in the same cycle. Two more cases are provoked while a frame is on the wire: a new request is raised, and the divider is changed. The bench then shows that neither the decoded frame nor the measured clock-low width moves.

// File: rtl/pcw_pkg.sv
// Shared constants, state types and the fixed write list for the
// three-wire panel register writer.
// Assumes an 8-bit address and 8-bit value per frame.
package pcw_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int SEQ_LEN = 5;
    localparam int IDX_W   = $clog2(SEQ_LEN);

    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPEN,
        S_LOW,
        S_HIGH,
        S_CLOSE
    } ser_state_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_ONE,
        C_SEQ
    } ctl_state_t;

    // Display-off write: register 05 gets 5E.
    localparam frame_t OFF_WORD = 16'h055E;

    // Power-on list, entry i in send order.
    function automatic frame_t power_on_word(input logic [IDX_W-1:0] i);
        case (i)
            3'd0:    return 16'h051E;
            3'd1:    return 16'h055E;
            3'd2:    return 16'h078D;
            3'd3:    return 16'h1301;
            default: return 16'h055F;
        endcase
    endfunction

endpackage

// File: rtl/pcw_halfper.sv
// Half-period timer.
// It captures the divider when a write is loaded. While the serializer is
// active, it pulses `tick` in the last system clock of every phase.
// Assumes `load` is only raised when a new frame begins.
module pcw_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_q);

    // Capture the divider on load and count system clocks within each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt   <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div_q));

    p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (div_q == $past(div_q)));

endmodule

// File: rtl/pcw_serializer.sv
// Frame serializer.
// It opens a frame by pulling select low, then sends FRAME_W bits MSB first.
// Each bit spends one phase with the clock low (data launched) and one with
// the clock high (panel samples). It closes with one select-high phase.
// A new frame may be loaded in the last cycle of that closing phase.
// Assumes `tick` marks the final cycle of each phase.
module pcw_serializer
    import pcw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go,
    input  frame_t frame_in,
    input  logic   tick,
    output logic   cs_n,
    output logic   sclk,
    output logic   sdo,
    output logic   fin,
    output logic   active
);

    localparam int BIT_W = $clog2(FRAME_W);

    ser_state_t       st;
    frame_t           shreg;
    logic [BIT_W-1:0] bits_left;

    // Phase sequencing, bit counting and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            shreg     <= '0;
            bits_left <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (go) begin
                        st        <= S_OPEN;
                        shreg     <= frame_in;
                        bits_left <= BIT_W'(FRAME_W - 1);
                    end
                end
                S_OPEN: begin
                    if (tick) st <= S_LOW;
                end
                S_LOW: begin
                    if (tick) st <= S_HIGH;
                end
                S_HIGH: begin
                    if (tick) begin
                        if (bits_left == '0) begin
                            st <= S_CLOSE;
                        end else begin
                            bits_left <= bits_left - 1'b1;
                            shreg     <= {shreg[FRAME_W-2:0], 1'b0};
                            st        <= S_LOW;
                        end
                    end
                end
                S_CLOSE: begin
                    if (tick) begin
                        if (go) begin
                            st        <= S_OPEN;
                            shreg     <= frame_in;
                            bits_left <= BIT_W'(FRAME_W - 1);
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Line levels decoded from the registered phase.
    always_comb begin
        cs_n   = !((st == S_OPEN) || (st == S_LOW) || (st == S_HIGH));
        sclk   = (st != S_LOW);
        sdo    = ((st == S_LOW) || (st == S_HIGH)) ? shreg[FRAME_W-1] : 1'b0;
        fin    = (st == S_CLOSE) && tick;
        active = (st != S_IDLE);
    end

    // Checking aid: count clock rises inside the current frame.
    logic             sclk_d;
    logic [BIT_W:0]   rise_cnt;

    // Track the previous clock level and rising edges while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b1;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sclk;
            if (cs_n)
                rise_cnt <= '0;
            else if (sclk && !sclk_d)
                rise_cnt <= rise_cnt + 1'b1;
        end
    end

    p_open_levels_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (sclk && !sdo));

    p_sdo_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk) && !$past(cs_n)) |-> $stable(sdo));

    p_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rise_cnt == (BIT_W+1)'(FRAME_W)));

endmodule

// File: rtl/pcw_sequencer.sv
// Request arbiter and write-list walker.
// In idle it accepts one request, with priority list > display-off >
// single write. It then keeps busy high until the last frame ends. For the
// list, it hands the next word to the serializer during the closing phase.
// Requests raised while busy are ignored.
module pcw_sequencer
    import pcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              off_start,
    input  logic              seq_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fin,
    output logic              go,
    output frame_t            frame,
    output logic              busy,
    output logic              done,
    output logic              seq_done
);

    ctl_state_t       st;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_nxt;
    logic             last_entry;

    assign idx_nxt    = idx + IDX_W'(1);
    assign last_entry = (idx == IDX_W'(SEQ_LEN - 1));
    assign busy       = (st != C_IDLE);

    // Choose the next frame and whether to launch it this cycle.
    always_comb begin
        go    = 1'b0;
        frame = {wr_addr, wr_data};
        if (st == C_IDLE) begin
            go = start || off_start || seq_start;
            if (seq_start)
                frame = power_on_word('0);
            else if (off_start)
                frame = OFF_WORD;
        end else if (st == C_SEQ && fin && !last_entry) begin
            go    = 1'b1;
            frame = power_on_word(idx_nxt);
        end
    end

    // Request state, list position and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= C_IDLE;
            idx      <= '0;
            done     <= 1'b0;
            seq_done <= 1'b0;
        end else begin
            done     <= fin;
            seq_done <= fin && (st == C_SEQ) && last_entry;
            case (st)
                C_IDLE: begin
                    idx <= '0;
                    if (seq_start)
                        st <= C_SEQ;
                    else if (off_start || start)
                        st <= C_ONE;
                end
                C_ONE: begin
                    if (fin) st <= C_IDLE;
                end
                C_SEQ: begin
                    if (fin) begin
                        if (last_entry) st <= C_IDLE;
                        else            idx <= idx_nxt;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IDX_W'(SEQ_LEN));

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> ((st == $past(st)) && (idx == $past(idx))));

endmodule

// File: rtl/panel_cfg_writer.sv
// Three-wire panel register writer, top level.
// It accepts single writes, the display-off write and the power-on list,
// and drives select, clock and data to the panel.
// Assumes the panel samples data on rising clock edges.
module panel_cfg_writer
    import pcw_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              start,
    input  logic              off_start,
    input  logic              seq_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              seq_done,
    output logic              pnl_cs_n,
    output logic              pnl_sclk,
    output logic              pnl_sdo
);

    logic   go;
    logic   fin;
    logic   tick;
    logic   active;
    frame_t frame;

    pcw_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .off_start (off_start),
        .seq_start (seq_start),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fin       (fin),
        .go        (go),
        .frame     (frame),
        .busy      (busy),
        .done      (done),
        .seq_done  (seq_done)
    );

    pcw_halfper #(.DIV_W(DIV_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (go),
        .run    (active),
        .div_in (half_div),
        .tick   (tick)
    );

    pcw_serializer u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .frame_in (frame),
        .tick     (tick),
        .cs_n     (pnl_cs_n),
        .sclk     (pnl_sclk),
        .sdo      (pnl_sdo),
        .fin      (fin),
        .active   (active)
    );

    p_busy_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_cs_n |-> busy);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_seq_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (done && !busy));

endmodule

// File: tb/sim_panel_cfg_writer.sv
module sim_panel_cfg_writer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_div = '0;
    logic       start = 1'b0;
    logic       off_start = 1'b0;
    logic       seq_start = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       busy, done, seq_done, pnl_cs_n, pnl_sclk, pnl_sdo;

    always #10 clk = ~clk;

    panel_cfg_writer #(.DIV_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .start(start),
        .off_start(off_start), .seq_start(seq_start), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done), .seq_done(seq_done),
        .pnl_cs_n(pnl_cs_n), .pnl_sclk(pnl_sclk), .pnl_sdo(pnl_sdo)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Pin-level frame decoder, sampled away from the active edge.
    logic [15:0] cap_frame [32];
    int          cap_bits  [32];
    int          cap_lmin  [32];
    int          cap_lmax  [32];
    bit          cap_open  [32];
    int  cap_n = 0, done_cnt = 0, sdone_cnt = 0, hi_viol = 0;
    bit  done_busy = 0, done_csn = 1;
    bit  prev_cs = 1, prev_sclk = 1, prev_sdo = 0, open_ok = 0;
    logic [15:0] sh = '0;
    int  nb = 0, lowrun = 0, lmin = 0, lmax = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !pnl_cs_n) begin
                open_ok = pnl_sclk && !pnl_sdo;
                sh = '0; nb = 0; lmin = 1000000; lmax = 0;
            end
            if (!pnl_cs_n && pnl_sclk && prev_sclk && !prev_cs && (pnl_sdo != prev_sdo))
                hi_viol++;
            if (!pnl_cs_n && !prev_sclk && pnl_sclk) begin
                sh = {sh[14:0], pnl_sdo};
                nb++;
                if (lowrun < lmin) lmin = lowrun;
                if (lowrun > lmax) lmax = lowrun;
            end
            if (!pnl_sclk) lowrun++; else lowrun = 0;
            if (!prev_cs && pnl_cs_n) begin
                if (cap_n < 32) begin
                    cap_frame[cap_n] = sh; cap_bits[cap_n] = nb;
                    cap_lmin[cap_n] = lmin; cap_lmax[cap_n] = lmax;
                    cap_open[cap_n] = open_ok;
                end
                cap_n++;
            end
            if (done) begin done_cnt++; done_busy = busy; done_csn = pnl_cs_n; end
            if (seq_done) sdone_cnt++;
        end
        prev_cs = pnl_cs_n; prev_sclk = pnl_sclk; prev_sdo = pnl_sdo;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // kind bits: 0 start, 1 off_start, 2 seq_start
    task automatic issue(input logic [2:0] kind, input logic [7:0] a,
                         input logic [7:0] d, input logic [7:0] dv);
        @(negedge clk);
        half_div = dv; wr_addr = a; wr_data = d;
        start = kind[0]; off_start = kind[1]; seq_start = kind[2];
        @(negedge clk);
        start = 0; off_start = 0; seq_start = 0;
        chk(busy == 1'b1 && pnl_cs_n == 1'b0, "R6", "busy/select after request",
            {busy, pnl_cs_n}, 2'b10);
    endtask

    task automatic wait_done(input int target);
        int k = 0;
        while (done_cnt < target && k < 20000) begin
            @(posedge clk);
            k++;
        end
        @(posedge clk);
        if (k >= 20000) chk(1'b0, "R6", "done timeout", done_cnt, target);
    endtask

    // addr, data, divider
    localparam logic [23:0] VEC [6] = '{
        24'h051E00, 24'hFFFF01, 24'h000002,
        24'hA55A03, 24'h800100, 24'h7FFE02
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base, dbase;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R2)
        chk({pnl_cs_n, pnl_sclk, pnl_sdo} == 3'b110, "R2", "idle lines",
            {pnl_cs_n, pnl_sclk, pnl_sdo}, 3'b110);
        chk(busy == 0 && done == 0 && seq_done == 0, "R6", "idle flags",
            {busy, done, seq_done}, 0);

        // Vector walk: R1, R2, R3, R4, R5, R6
        for (int i = 0; i < 6; i++) begin
            base = cap_n; dbase = done_cnt;
            issue(3'b001, VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            wait_done(dbase + 1);
            chk(cap_n == base + 1, "R4", "frame count", cap_n - base, 1);
            chk(cap_frame[base] == VEC[i][23:8], "R1", "frame word",
                cap_frame[base], VEC[i][23:8]);
            chk(cap_bits[base] == 16, "R4", "clock rises", cap_bits[base], 16);
            chk(cap_open[base], "R2", "open levels", cap_open[base], 1);
            chk(cap_lmin[base] == VEC[i][7:0] + 1 && cap_lmax[base] == VEC[i][7:0] + 1,
                "R5", "clock low width", cap_lmax[base], VEC[i][7:0] + 1);
            chk(!done_busy && done_csn, "R6", "busy low with done",
                {done_busy, done_csn}, 2'b01);
        end
        chk(hi_viol == 0, "R3", "data moved while clock high", hi_viol, 0);

        // R7: request while busy is ignored
        base = cap_n; dbase = done_cnt;
        issue(3'b001, 8'h3C, 8'hC3, 8'd1);
        repeat (20) @(negedge clk);
        wr_addr = 8'hFF; wr_data = 8'hFF; start = 1; off_start = 1; seq_start = 1;
        @(negedge clk);
        start = 0; off_start = 0; seq_start = 0;
        wait_done(dbase + 1);
        repeat (200) @(posedge clk);
        chk(cap_n == base + 1, "R7", "frames after busy request", cap_n - base, 1);
        chk(cap_frame[base] == 16'h3CC3, "R7", "frame kept", cap_frame[base], 16'h3CC3);
        chk(busy == 0 && done_cnt == dbase + 1, "R7", "no extra write",
            done_cnt - dbase, 1);

        // R5: divider change mid-frame has no effect
        base = cap_n; dbase = done_cnt;
        issue(3'b001, 8'h12, 8'h34, 8'd2);
        repeat (30) @(negedge clk);
        half_div = 8'd0;
        wait_done(dbase + 1);
        chk(cap_lmin[base] == 3 && cap_lmax[base] == 3, "R5", "captured divider",
            cap_lmin[base], 3);

        // R10: display-off ignores address/data
        base = cap_n; dbase = done_cnt;
        issue(3'b010, 8'hAA, 8'hBB, 8'd1);
        wait_done(dbase + 1);
        chk(cap_frame[base] == 16'h055E, "R10", "off word", cap_frame[base], 16'h055E);

        // R8, R9: power-on list
        base = cap_n; dbase = done_cnt;
        issue(3'b100, 8'h00, 8'h00, 8'd1);
        wait_done(dbase + 5);
        chk(cap_n == base + 5, "R8", "list frames", cap_n - base, 5);
        chk(cap_frame[base] == 16'h051E, "R8", "entry 0", cap_frame[base], 16'h051E);
        chk(cap_frame[base+1] == 16'h055E, "R8", "entry 1", cap_frame[base+1], 16'h055E);
        chk(cap_frame[base+2] == 16'h078D, "R8", "entry 2", cap_frame[base+2], 16'h078D);
        chk(cap_frame[base+3] == 16'h1301, "R8", "entry 3", cap_frame[base+3], 16'h1301);
        chk(cap_frame[base+4] == 16'h055F, "R8", "entry 4", cap_frame[base+4], 16'h055F);
        chk(done_cnt == dbase + 5 && sdone_cnt == 1, "R9", "done/seq_done pulses",
            sdone_cnt, 1);
        chk(!done_busy, "R9", "busy low at list end", done_busy, 0);

        // R11: priority with all three requests together
        base = cap_n; dbase = done_cnt;
        issue(3'b111, 8'h44, 8'h55, 8'd0);
        wait_done(dbase + 5);
        repeat (100) @(posedge clk);
        chk(cap_n == base + 5 && cap_frame[base] == 16'h051E, "R11", "list wins",
            cap_frame[base], 16'h051E);
        chk(sdone_cnt == 2, "R11", "second list end", sdone_cnt, 2);
        base = cap_n; dbase = done_cnt;
        issue(3'b011, 8'h44, 8'h55, 8'd0);
        wait_done(dbase + 1);
        chk(cap_frame[base] == 16'h055E, "R11", "off over single",
            cap_frame[base], 16'h055E);

        chk(hi_viol == 0, "R3", "data stable while clock high", hi_viol, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule